// File: doc/BRIEF.md
# Cartridge Bank Controller with Latched Clock

This block sits between a CPU bus and a cartridge's memories. It decodes writes into four control regions: RAM/clock access enable, ROM bank number, RAM bank or clock-register select, and a latch command. It drives the ROM and RAM bank numbers that the memory decoders use. A clock of seconds, minutes, hours and a 9-bit day count advances on a one-pulse-per-second tick input.

When the clock is mapped, the external RAM window is taken over by one of five clock registers. Reads in that window return a frozen snapshot of the counters, taken by a write sequence to the latch region. Writes in the window set both the running counter and its snapshot. A halt bit stops the clock, and a sticky flag records a wrap of the day count.

Top module: `cart_rtc_mapper`

## Requirements
- R1: A write with region code 0 (address bits 15:13) and data 0x0A turns RAM/clock access on, and data 0x00 turns it off. Any other data value leaves access unchanged. `ram_en` is high only while access is on and the clock is not mapped.
- R2: A write to region 1 loads the low 7 data bits as the ROM bank, and a value of 0 is stored as 1. The ROM bank is 1 after reset.
- R3: A region 2 write of 0 to 3 sets `ram_bank` to that value and unmaps the clock.
- R4: A region 2 write of 0x08 to 0x0C maps the clock and selects clock register (value minus 8). Any other value changes neither the bank, the mapping nor the selected register.
- R5: A read strobe gives `rd_valid` one cycle later, with `rd_data` holding the data. When region 5 is addressed, access is on and the clock is mapped, the data is the snapshot of the selected register. Otherwise it is 0xFF. Register 0 is seconds in bits 5:0, register 1 is minutes in bits 5:0, register 2 is hours in bits 4:0, register 3 is day bits 7:0, and register 4 is {overflow, halt, 00000, day bit 8}. Unused bits read 0.
- R6: A region 3 write of 0x01 while unlatched copies the running counters into the snapshot and enters the latched state. A write of 0x00 while latched leaves the latched state. A write of 0x01 while already latched does nothing, and the snapshot holds while the clock runs.
- R7: Each tick advances the seconds. Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. Each wrap carries into the next field in the same cycle.
- R8: The day count wraps from 511 to 0 and sets the overflow bit (register 4 bit 7). The bit stays set until register 4 is written with bit 7 clear.
- R9: While the halt bit (register 4 bit 6) is set, ticks do not advance the counters.
- R10: A region 5 write, with access on and the clock mapped, loads the selected counter and its snapshot at once. If a tick arrives in the same cycle, it is dropped.
- R11: Reset sets the ROM bank to 1, sets the RAM bank to 0, unmaps the clock, turns access off, and clears all counters, the snapshot, the latched state, halt and overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr_top | input | 3 | CPU address bits 15:13 (region code) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe, one cycle per read |
| sec_tick | input | 1 | One-cycle pulse once per second |
| rom_bank | output | 7 | Selected switchable ROM bank |
| ram_bank | output | 2 | Selected external RAM bank |
| ram_en | output | 1 | External RAM window active |
| rd_valid | output | 1 | Read data valid, one cycle after `cpu_rd` |
| rd_data | output | 8 | Read data |

## Verification
The clock is preset close to a full cascade (58 s, 59 min, 23 h, day 511) and then ticked once and once more. This separates a plain seconds step from a wrap that carries through every field and sets overflow. Reads of the snapshot taken while the clock keeps ticking, taken after a second latch command, and taken after a full unlatch/latch cycle separate a frozen copy from a live one. A window write in the same cycle as a tick, and ticks while halted, show that writes and halt take priority. Illegal select values and reads outside the window or with access off must leave the bank outputs unchanged and return 0xFF.

// File: rtl/mbc_rtc_pkg.sv
package mbc_rtc_pkg;
   localparam int RTC_NREG = 5;

   localparam logic [2:0] RGN_ENABLE = 3'd0;
   localparam logic [2:0] RGN_ROM    = 3'd1;
   localparam logic [2:0] RGN_RAMSEL = 3'd2;
   localparam logic [2:0] RGN_LATCH  = 3'd3;
   localparam logic [2:0] RGN_WINDOW = 3'd5;

   localparam logic [2:0] CLK_SEC   = 3'd0;
   localparam logic [2:0] CLK_MIN   = 3'd1;
   localparam logic [2:0] CLK_HOUR  = 3'd2;
   localparam logic [2:0] CLK_DAYLO = 3'd3;
   localparam logic [2:0] CLK_DAYHI = 3'd4;

   typedef logic [7:0] byte_t;

   // Keeps only the bits that the selected clock register implements.
   function automatic byte_t clk_field_mask(input logic [2:0] idx, input byte_t d);
      case (idx)
         CLK_SEC, CLK_MIN: return {2'b00, d[5:0]};
         CLK_HOUR:         return {3'b000, d[4:0]};
         CLK_DAYLO:        return d;
         default:          return {d[7], d[6], 5'b00000, d[0]};
      endcase
   endfunction
endpackage

// File: rtl/mbc_ctrl_regs.sv
module mbc_ctrl_regs
   import mbc_rtc_pkg::*;
#(
   parameter int ROM_BANK_W = 7,
   parameter int RAM_BANK_W = 2,
   parameter bit ZERO_REMAP = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [2:0]            region,
   input  byte_t                 wdata,
   output logic                  acc_en,
   output logic [ROM_BANK_W-1:0] rom_bank,
   output logic [RAM_BANK_W-1:0] ram_bank,
   output logic                  clk_map,
   output logic [2:0]            clk_idx,
   output logic                  snap_take
);
   localparam int RAM_BANKS = 1 << RAM_BANK_W;

   logic                  latched;
   logic [ROM_BANK_W-1:0] rom_next;
   logic                  sel_ram;
   logic                  sel_clk;

   generate
      if (ZERO_REMAP) begin : g_remap
         always_comb
            rom_next = (wdata[ROM_BANK_W-1:0] == '0) ? ROM_BANK_W'(1) : wdata[ROM_BANK_W-1:0];
      end else begin : g_direct
         assign rom_next = wdata[ROM_BANK_W-1:0];
      end
   endgenerate

   assign sel_ram   = wdata < 8'(RAM_BANKS);
   assign sel_clk   = (wdata >= 8'h08) && (wdata <= 8'h0C);
   assign snap_take = wr_en && (region == RGN_LATCH) && !latched && (wdata == 8'h01);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_en   <= 1'b0;
         rom_bank <= ROM_BANK_W'(1);
         ram_bank <= '0;
         clk_map  <= 1'b0;
         clk_idx  <= CLK_SEC;
         latched  <= 1'b0;
      end else if (wr_en) begin
         case (region)
            RGN_ENABLE: begin
               if (wdata == 8'h0A)      acc_en <= 1'b1;
               else if (wdata == 8'h00) acc_en <= 1'b0;
            end
            RGN_ROM: rom_bank <= rom_next;
            RGN_RAMSEL: begin
               if (sel_ram) begin
                  ram_bank <= wdata[RAM_BANK_W-1:0];
                  clk_map  <= 1'b0;
               end else if (sel_clk) begin
                  clk_idx <= wdata[2:0];   // 0x08..0x0C -> 0..4
                  clk_map <= 1'b1;
               end
            end
            RGN_LATCH: begin
               if (latched && wdata == 8'h00)       latched <= 1'b0;
               else if (!latched && wdata == 8'h01) latched <= 1'b1;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rtc_wrap_cnt.sv
module rtc_wrap_cnt #(
   parameter int W     = 6,
   parameter int LIMIT = 59
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] val,
   output logic         wrap
);
   assign wrap = inc && (val == W'(LIMIT));

   always_ff @(posedge clk) begin
      if (!rst_n)    val <= '0;
      else if (load) val <= load_val;
      else if (inc)  val <= wrap ? '0 : val + 1'b1;
   end
endmodule

// File: rtl/rtc_live.sv
module rtc_live
   import mbc_rtc_pkg::*;
(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tick,
   input  logic                      wr_en,
   input  logic [2:0]                wr_idx,
   input  byte_t                     wr_byte,
   output logic [RTC_NREG-1:0][7:0]  live_regs,
   output logic                      halt,
   output logic                      ovf
);
   logic       step;
   logic       sec_w, min_w, hr_w, day_w;
   logic [5:0] sec, mins;
   logic [4:0] hrs;
   logic [8:0] day;
   logic [RTC_NREG-1:0] wr_sel;

   genvar g;
   generate
      for (g = 0; g < RTC_NREG; g++) begin : g_sel
         assign wr_sel[g] = wr_en && (wr_idx == 3'(g));
      end
   endgenerate

   assign step = tick && !halt && !wr_en;

   rtc_wrap_cnt #(.W(6), .LIMIT(59)) u_sec (
      .clk(clk), .rst_n(rst_n), .inc(step), .load(wr_sel[CLK_SEC]),
      .load_val(wr_byte[5:0]), .val(sec), .wrap(sec_w));

   rtc_wrap_cnt #(.W(6), .LIMIT(59)) u_min (
      .clk(clk), .rst_n(rst_n), .inc(sec_w), .load(wr_sel[CLK_MIN]),
      .load_val(wr_byte[5:0]), .val(mins), .wrap(min_w));

   rtc_wrap_cnt #(.W(5), .LIMIT(23)) u_hour (
      .clk(clk), .rst_n(rst_n), .inc(min_w), .load(wr_sel[CLK_HOUR]),
      .load_val(wr_byte[4:0]), .val(hrs), .wrap(hr_w));

   rtc_wrap_cnt #(.W(9), .LIMIT(511)) u_day (
      .clk(clk), .rst_n(rst_n), .inc(hr_w),
      .load(wr_sel[CLK_DAYLO] || wr_sel[CLK_DAYHI]),
      .load_val(wr_sel[CLK_DAYHI] ? {wr_byte[0], day[7:0]} : {day[8], wr_byte}),
      .val(day), .wrap(day_w));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt <= 1'b0;
         ovf  <= 1'b0;
      end else if (wr_sel[CLK_DAYHI]) begin
         ovf  <= wr_byte[7];
         halt <= wr_byte[6];
      end else if (day_w) begin
         ovf <= 1'b1;
      end
   end

   assign live_regs[CLK_SEC]   = {2'b00, sec};
   assign live_regs[CLK_MIN]   = {2'b00, mins};
   assign live_regs[CLK_HOUR]  = {3'b000, hrs};
   assign live_regs[CLK_DAYLO] = day[7:0];
   assign live_regs[CLK_DAYHI] = {ovf, halt, 5'b00000, day[8]};
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
   import mbc_rtc_pkg::*;
(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      take,
   input  logic                      wr_en,
   input  logic [2:0]                wr_idx,
   input  byte_t                     wr_byte,
   input  logic [RTC_NREG-1:0][7:0]  live_regs,
   input  logic [2:0]                rd_idx,
   output byte_t                     rd_byte,
   output logic [RTC_NREG-1:0][7:0]  snap_regs
);
   genvar g;
   generate
      for (g = 0; g < RTC_NREG; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n)                                 snap_regs[g] <= 8'h00;
            else if (take)                              snap_regs[g] <= live_regs[g];
            else if (wr_en && wr_idx == 3'(g))          snap_regs[g] <= wr_byte;
         end
      end
   endgenerate

   always_comb begin
      rd_byte = 8'hFF;
      for (int i = 0; i < RTC_NREG; i++)
         if (rd_idx == 3'(i)) rd_byte = snap_regs[i];
   end
endmodule

// File: rtl/cart_rtc_mapper.sv
module cart_rtc_mapper
   import mbc_rtc_pkg::*;
#(
   parameter int ROM_BANK_W = 7,
   parameter int RAM_BANK_W = 2,
   parameter bit ZERO_REMAP = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2:0]            cpu_addr_top,
   input  logic [7:0]            cpu_wdata,
   input  logic                  cpu_wr,
   input  logic                  cpu_rd,
   input  logic                  sec_tick,
   output logic [ROM_BANK_W-1:0] rom_bank,
   output logic [RAM_BANK_W-1:0] ram_bank,
   output logic                  ram_en,
   output logic                  rd_valid,
   output logic [7:0]            rd_data
);
   generate
      if (ROM_BANK_W < 1 || ROM_BANK_W > 8 || RAM_BANK_W < 1 || RAM_BANK_W > 3) begin : g_bad_cfg
         $error("cart_rtc_mapper: bank widths out of range");
      end
   endgenerate

   logic                      acc_en;
   logic                      clk_map;
   logic [2:0]                clk_idx;
   logic                      snap_take;
   logic                      win_hit;
   logic                      win_wr;
   byte_t                     wr_masked;
   byte_t                     snap_byte;
   logic                      halt;
   logic                      ovf;
   logic [RTC_NREG-1:0][7:0]  live_regs;
   logic [RTC_NREG-1:0][7:0]  snap_regs;

   mbc_ctrl_regs #(
      .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W), .ZERO_REMAP(ZERO_REMAP)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr), .region(cpu_addr_top), .wdata(cpu_wdata),
      .acc_en(acc_en), .rom_bank(rom_bank), .ram_bank(ram_bank),
      .clk_map(clk_map), .clk_idx(clk_idx), .snap_take(snap_take));

   assign win_hit   = (cpu_addr_top == RGN_WINDOW) && acc_en && clk_map;
   assign win_wr    = cpu_wr && win_hit;
   assign wr_masked = clk_field_mask(clk_idx, cpu_wdata);
   assign ram_en    = acc_en && !clk_map;

   rtc_live u_live (
      .clk(clk), .rst_n(rst_n), .tick(sec_tick), .wr_en(win_wr), .wr_idx(clk_idx),
      .wr_byte(wr_masked), .live_regs(live_regs), .halt(halt), .ovf(ovf));

   rtc_snapshot u_snap (
      .clk(clk), .rst_n(rst_n), .take(snap_take), .wr_en(win_wr), .wr_idx(clk_idx),
      .wr_byte(wr_masked), .live_regs(live_regs), .rd_idx(clk_idx),
      .rd_byte(snap_byte), .snap_regs(snap_regs));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= 8'hFF;
      end else begin
         rd_valid <= cpu_rd;
         if (cpu_rd) rd_data <= win_hit ? snap_byte : 8'hFF;
      end
   end
endmodule

// File: rtl/mbc_rtc_checker.sv
module mbc_rtc_checker #(
   parameter int ROM_BANK_W = 7,
   parameter int RAM_BANK_W = 2,
   parameter bit ZERO_REMAP = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [2:0]            cpu_addr_top,
   input logic [7:0]            cpu_wdata,
   input logic                  cpu_wr,
   input logic                  cpu_rd,
   input logic [ROM_BANK_W-1:0] rom_bank,
   input logic                  rd_valid,
   input logic                  acc_en,
   input logic                  clk_map,
   input logic [2:0]            clk_idx,
   input logic                  halt,
   input logic                  ovf,
   input logic [7:0]            live_sec,
   input logic                  snap_take,
   input logic                  win_wr,
   input logic [39:0]           snap_flat
);
   assert_en_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr_top == 3'd0 && cpu_wdata == 8'h0A) |=> acc_en);

   assert_rom_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ZERO_REMAP) || (rom_bank != '0));

   assert_map_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr_top == 3'd2 && cpu_wdata < 8'(1 << RAM_BANK_W)) |=> !clk_map);

   assert_map_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr_top == 3'd2 && cpu_wdata >= 8'h08 && cpu_wdata <= 8'h0C) |=> clk_map);

   assert_rd_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd |=> rd_valid);

   assert_rd_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |=> !rd_valid);

   assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!snap_take && !win_wr) |=> $stable(snap_flat));

   assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !(win_wr && clk_idx == 3'd4)) |=> ovf);

   assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !win_wr) |=> $stable(live_sec));
endmodule

bind cart_rtc_mapper mbc_rtc_checker #(
   .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W), .ZERO_REMAP(ZERO_REMAP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_addr_top(cpu_addr_top), .cpu_wdata(cpu_wdata),
   .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rom_bank(rom_bank), .rd_valid(rd_valid),
   .acc_en(acc_en), .clk_map(clk_map), .clk_idx(clk_idx), .halt(halt), .ovf(ovf),
   .live_sec(live_regs[0]), .snap_take(snap_take), .win_wr(win_wr), .snap_flat(snap_regs)
);

// File: tb/cart_rtc_mapper_tb_top.sv
module cart_rtc_mapper_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cpu_addr_top = 3'd0;
   logic [7:0] cpu_wdata = 8'h00;
   logic       cpu_wr = 1'b0;
   logic       cpu_rd = 1'b0;
   logic       sec_tick = 1'b0;
   logic [6:0] rom_bank;
   logic [1:0] ram_bank;
   logic       ram_en;
   logic       rd_valid;
   logic [7:0] rd_data;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   cart_rtc_mapper dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_addr_top(cpu_addr_top), .cpu_wdata(cpu_wdata),
      .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .sec_tick(sec_tick), .rom_bank(rom_bank),
      .ram_bank(ram_bank), .ram_en(ram_en), .rd_valid(rd_valid), .rd_data(rd_data));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] rgn, input logic [7:0] d, input bit with_tick = 0);
      @(negedge clk);
      cpu_addr_top = rgn; cpu_wdata = d; cpu_wr = 1'b1; sec_tick = with_tick;
      @(negedge clk);
      cpu_wr = 1'b0; sec_tick = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] rgn, input logic [7:0] exp, input string tag);
      @(negedge clk);
      cpu_addr_top = rgn; cpu_rd = 1'b1;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      cpu_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); sec_tick = 1'b1;
         @(negedge clk); sec_tick = 1'b0;
      end
   endtask

   task automatic relatch();
      bus_write(3'd3, 8'h00);
      bus_write(3'd3, 8'h01);
   endtask

   task automatic wr_clk(input int idx, input logic [7:0] v);
      bus_write(3'd2, 8'(8 + idx));
      bus_write(3'd5, v);
   endtask

   task automatic rd_clk(input int idx, input logic [7:0] exp, input string tag);
      bus_write(3'd2, 8'(8 + idx));
      bus_read(3'd5, exp, tag);
   endtask

   // Monitor: pops the scoreboard whenever the design presents read data.
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL R5 unexpected read actual=%0h expected=none", rd_data);
         end else begin
            check(tag_q.pop_front(), rd_data, exp_q.pop_front());
         end
      end
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 rom_bank", rom_bank, 1);
      check("R11 ram_bank", ram_bank, 0);
      check("R11 ram_en", ram_en, 0);
      bus_read(3'd5, 8'hFF, "R5 access off");
      bus_write(3'd0, 8'h0A);
      bus_write(3'd3, 8'h01);
      for (int i = 0; i < 5; i++) rd_clk(i, 8'h00, "R11 clock cleared");

      // R2 ROM bank
      bus_write(3'd1, 8'h85); check("R2 low seven bits", rom_bank, 5);
      bus_write(3'd1, 8'h00); check("R2 zero to one", rom_bank, 1);
      bus_write(3'd1, 8'h80); check("R2 masked zero to one", rom_bank, 1);
      bus_write(3'd1, 8'h7F); check("R2 top bank", rom_bank, 8'h7F);

      // R1 and R3 with the clock unmapped
      bus_write(3'd2, 8'h03);
      check("R3 bank 3", ram_bank, 3);
      check("R3 unmaps clock", ram_en, 1);
      bus_write(3'd0, 8'h55); check("R1 other value keeps on", ram_en, 1);
      bus_write(3'd0, 8'h00); check("R1 disable", ram_en, 0);
      bus_write(3'd0, 8'h33); check("R1 other value keeps off", ram_en, 0);
      bus_write(3'd0, 8'h0A); check("R1 enable", ram_en, 1);

      // R4 mapping and ignored selects
      bus_write(3'd2, 8'h09); check("R4 maps clock", ram_en, 0);
      bus_write(3'd2, 8'h05);
      check("R4 ignored 05 bank", ram_bank, 3);
      check("R4 ignored 05 map", ram_en, 0);
      bus_write(3'd2, 8'h0D);
      check("R4 ignored 0D map", ram_en, 0);
      bus_read(3'd5, 8'h00, "R4 select kept after 0D");
      wr_clk(1, 8'h2A);
      bus_write(3'd2, 8'h0D);
      bus_read(3'd5, 8'h2A, "R4 still register 1");

      // R10 window writes reach the snapshot; masks per R5
      wr_clk(0, 8'hFA);
      rd_clk(0, 8'h3A, "R5 seconds mask");
      wr_clk(0, 8'd58); wr_clk(1, 8'd59); wr_clk(2, 8'd23);
      wr_clk(3, 8'hFF); wr_clk(4, 8'h01);
      rd_clk(0, 8'd58, "R10 sec snapshot");
      rd_clk(2, 8'd23, "R10 hour snapshot");
      rd_clk(4, 8'h01, "R10 day high snapshot");

      // R7 step and full cascade, R8 day overflow
      ticks(1); relatch();
      rd_clk(0, 8'd59, "R7 second step");
      rd_clk(1, 8'd59, "R7 minute held");
      ticks(1); relatch();
      rd_clk(0, 8'd0, "R7 sec wrap");
      rd_clk(1, 8'd0, "R7 min wrap");
      rd_clk(2, 8'd0, "R7 hour wrap");
      rd_clk(3, 8'd0, "R8 day low wrap");
      rd_clk(4, 8'h80, "R8 overflow set");

      // R6 snapshot holds while latched
      ticks(3);
      rd_clk(0, 8'd0, "R6 snapshot frozen");
      bus_write(3'd3, 8'h01);
      rd_clk(0, 8'd0, "R6 second latch ignored");
      relatch();
      rd_clk(0, 8'd3, "R6 relatch copies");
      rd_clk(4, 8'h80, "R8 overflow sticky");

      // R9 halt
      wr_clk(4, 8'hC0);
      rd_clk(4, 8'hC0, "R9 halt readback");
      ticks(5); relatch();
      rd_clk(0, 8'd3, "R9 halted seconds");
      wr_clk(4, 8'h00);
      ticks(2); relatch();
      rd_clk(0, 8'd5, "R9 resumed seconds");
      rd_clk(4, 8'h00, "R8 overflow cleared by write");

      // R10 write wins over a same-cycle tick
      bus_write(3'd2, 8'h08);
      bus_write(3'd5, 8'd20, 1);
      relatch();
      rd_clk(0, 8'd20, "R10 tick dropped");
      ticks(1); relatch();
      rd_clk(0, 8'd21, "R10 counting resumes");

      // R5 reads that miss the window
      bus_read(3'd6, 8'hFF, "R5 outside window");
      bus_write(3'd0, 8'h00);
      bus_read(3'd5, 8'hFF, "R5 access off");
      bus_write(3'd0, 8'h0A);
      bus_write(3'd2, 8'h00);
      check("R3 bank 0", ram_bank, 0);
      check("R3 ram_en back", ram_en, 1);
      bus_read(3'd5, 8'hFF, "R5 clock unmapped");

      repeat (3) @(negedge clk);
      check("R5 all reads answered", exp_q.size(), 0);
      done = 1'b1;
      summary();
   end
endmodule